// File: doc/BRIEF.md
# Memory Window Access Port

This block sits behind a debug link and presents a small bank of 32-bit registers, each selected by a byte offset. Two of these registers hold state: a control word and the transfer address. Three are fixed words that describe the port: a configuration word, a base pointer to a debug register block or lookup table, and an identification word. The remaining registers store nothing. Each one is a window onto system memory, and an access to it starts one 32-bit transaction on a simple request/ready memory bus.

The direct data window reaches the word at the transfer address. The four banked windows reach the four consecutive words of the 16-byte-aligned block that contains the transfer address. Writes through a window are posted: the register access is answered at once and the memory write completes in the background. Reads through a window are answered only when memory returns the data.

While a memory transaction is outstanding, the control word shows a busy flag and further window accesses are refused with a WAIT status. An abort input drops the outstanding transaction. A host uses the port by setting the transfer address and then reading or writing the windows.

Top module: `mem_window_port`

## Requirements
- R1: Out of reset, `rsp_valid` and `mem_req` are low, and both the control word (offset 0x00) and the transfer address (offset 0x04) read as zero.
- R2: The transfer address at 0x04 is fully readable and writable. In the control word at 0x00, bits [6:0] are writable storage, bit 7 is a read-only busy flag, and bits [31:8] read as zero.
- R3: Offsets 0xF4, 0xF8 and 0xFC return the parameters `CFG_WORD`, `BASE_WORD` and `ID_WORD`.
- R4: A write to the direct window at 0x0C issues one memory write (`mem_we`=1) at {TAR[31:2],2'b00} with the written data. It is answered with status OK (`rsp_ack`=2'b00) on the cycle after the request.
- R5: A read of the direct window at 0x0C issues one memory read (`mem_we`=0) at {TAR[31:2],2'b00}. It is answered with status OK and `mem_rdata` on the cycle after the memory accepts with `mem_ready`.
- R6: A banked window at offset 0x10+4·n (n = 0..3) accesses memory at {TAR[31:4], n[1:0], 2'b00}, for both reads and writes.
- R7: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle in which `mem_ready` is high or an abort occurs. Each accepted window access produces exactly one transaction.
- R8: While a transaction is outstanding, control-word bit 7 reads 1. A window access in that time is answered with WAIT (`rsp_ack`=2'b01) and read data zero, and it starts no transaction.
- R9: Writes to the read-only words, to undefined offsets (0x08, for example) or to offsets whose bits [1:0] are not zero change nothing and start no transaction. Reads of undefined or misaligned offsets return zero. Every such access is answered with OK on the next cycle.
- R10: An `abort_req` pulse while busy drops `mem_req` on the next cycle and clears the busy flag. An aborted read is answered with status ABORT (`rsp_ack`=2'b10) and data zero. When idle, an abort has no effect.
- R11: Every register access gets exactly one response. For non-window registers, that response arrives on the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Register write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_ack | output | 2 | 00 OK, 01 WAIT, 10 ABORT |
| rsp_rdata | output | 32 | Register read data |
| abort_req | input | 1 | Drop the outstanding memory transaction |
| mem_req | output | 1 | Memory request held until ready |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with ready |
| mem_ready | input | 1 | Memory accepts the current request |

## Verification
The assertions assume that the host keeps at most one register access in flight: after a window read, it sends nothing more until the response arrives. They also assume that `mem_ready` is high only while `mem_req` is high, and that an abort does not coincide with a new window read. The stimulus follows these rules. Each task waits for its response before it returns. The bench's memory model raises ready only for a live request, after a programmable latency. The busy-overlap cases issue only posted writes and register reads while a transaction is outstanding, and aborts are pulsed only in the middle of a long memory latency.

// File: rtl/mwp_pkg.sv
package mwp_pkg;

    localparam int DW        = 32;
    localparam int AW        = 32;
    localparam int OFS_W     = 8;
    localparam int CTRL_CFG_W = 7;
    localparam int BUSY_BIT  = 7;
    localparam int NBANK     = 4;
    localparam int BANK_W    = $clog2(NBANK);
    localparam int BLK_LSB   = BANK_W + 2;

    localparam logic [OFS_W-1:0] OFS_CTRL  = 8'h00;
    localparam logic [OFS_W-1:0] OFS_ADDR  = 8'h04;
    localparam logic [OFS_W-1:0] OFS_WIN   = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_BANK0 = 8'h10;
    localparam logic [OFS_W-1:0] OFS_CFG   = 8'hF4;
    localparam logic [OFS_W-1:0] OFS_BASE  = 8'hF8;
    localparam logic [OFS_W-1:0] OFS_IDENT = 8'hFC;

    typedef enum logic [1:0] {
        ACK_OK    = 2'b00,
        ACK_WAIT  = 2'b01,
        ACK_ABORT = 2'b10
    } ack_e;

    typedef enum logic [2:0] {
        RK_NONE, RK_CTRL, RK_ADDR, RK_DATA, RK_CFG, RK_BASE, RK_IDENT
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e           kind;
        logic                banked;
        logic [BANK_W-1:0]   bank;
    } reg_dec_t;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } mem_cmd_t;

    function automatic logic [AW-1:0] window_addr(
        input logic [AW-1:0]     tar,
        input logic              banked,
        input logic [BANK_W-1:0] bank
    );
        if (banked)
            return {tar[AW-1:BLK_LSB], bank, 2'b00};
        return {tar[AW-1:2], 2'b00};
    endfunction

endpackage

// File: rtl/mwp_decode.sv
module mwp_decode
    import mwp_pkg::*;
(
    input  logic [OFS_W-1:0] ofs,
    output reg_dec_t         dec
);
    always_comb begin
        dec = '{kind: RK_NONE, banked: 1'b0, bank: '0};
        if (ofs[1:0] == 2'b00) begin
            unique case (ofs)
                OFS_CTRL:  dec.kind = RK_CTRL;
                OFS_ADDR:  dec.kind = RK_ADDR;
                OFS_WIN:   dec.kind = RK_DATA;
                OFS_CFG:   dec.kind = RK_CFG;
                OFS_BASE:  dec.kind = RK_BASE;
                OFS_IDENT: dec.kind = RK_IDENT;
                default:   dec.kind = RK_NONE;
            endcase
            for (int n = 0; n < NBANK; n++) begin
                if (ofs == OFS_W'(int'(OFS_BANK0) + 4 * n)) begin
                    dec.kind   = RK_DATA;
                    dec.banked = 1'b1;
                    dec.bank   = BANK_W'(n);
                end
            end
        end
    end
endmodule

// File: rtl/mwp_regs.sv
module mwp_regs
    import mwp_pkg::*;
#(
    parameter logic [DW-1:0] CFG_WORD  = 32'h0000_0001,
    parameter logic [DW-1:0] BASE_WORD = 32'hE00F_F003,
    parameter logic [DW-1:0] ID_WORD   = 32'h2477_0011
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  reg_kind_e     kind,
    input  logic [DW-1:0] wdata,
    input  logic          busy,
    output logic [AW-1:0] tar,
    output logic [DW-1:0] rdata
);
    logic [CTRL_CFG_W-1:0] ctrl_q;
    logic [AW-1:0]         tar_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            tar_q  <= '0;
        end else if (wr_en) begin
            if (kind == RK_CTRL) ctrl_q <= wdata[CTRL_CFG_W-1:0];
            if (kind == RK_ADDR) tar_q  <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (kind)
            RK_CTRL: begin
                rdata[CTRL_CFG_W-1:0] = ctrl_q;
                rdata[BUSY_BIT]       = busy;
            end
            RK_ADDR:  rdata = tar_q;
            RK_CFG:   rdata = CFG_WORD;
            RK_BASE:  rdata = BASE_WORD;
            RK_IDENT: rdata = ID_WORD;
            default:  rdata = '0;
        endcase
    end

    assign tar = tar_q;

    // R2: writes to the transfer address are visible on the next cycle
    p_tar_write_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en && kind == RK_ADDR |=> tar == $past(wdata));
endmodule

// File: rtl/mwp_xfer.sv
module mwp_xfer
    import mwp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  mem_cmd_t      cmd,
    input  logic          abort,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          rd_done,
    output logic          rd_abort,
    output logic [DW-1:0] rd_data
);
    typedef enum logic [1:0] {XS_IDLE, XS_WRITE, XS_READ} xstate_e;

    xstate_e  state_q;
    mem_cmd_t cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= XS_IDLE;
            cmd_q    <= '0;
            rd_done  <= 1'b0;
            rd_abort <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_done  <= 1'b0;
            rd_abort <= 1'b0;
            if (state_q == XS_IDLE) begin
                if (launch) begin
                    state_q <= cmd.we ? XS_WRITE : XS_READ;
                    cmd_q   <= cmd;
                end
            end else if (abort) begin
                state_q  <= XS_IDLE;
                rd_abort <= (state_q == XS_READ);
            end else if (mem_ready) begin
                state_q <= XS_IDLE;
                rd_done <= (state_q == XS_READ);
                rd_data <= mem_rdata;
            end
        end
    end

    assign mem_req   = (state_q != XS_IDLE);
    assign mem_we    = cmd_q.we;
    assign mem_addr  = cmd_q.addr;
    assign mem_wdata = cmd_q.wdata;
    assign busy      = mem_req;

    // R7: request and its fields hold until accepted or aborted
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready && !abort |=>
            mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
    // R7: an accepted transaction is not repeated
    p_single_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ready && !launch |=> !mem_req);
    // R10: abort drops the request
    p_abort_drop_r10: assert property (@(posedge clk) disable iff (rst)
        abort && mem_req |=> !mem_req);
    // R5: read completion and read abort never coincide
    p_rd_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(rd_done && rd_abort));
endmodule

// File: rtl/mem_window_port.sv
module mem_window_port
    import mwp_pkg::*;
#(
    parameter logic [31:0] CFG_WORD  = 32'h0000_0001,
    parameter logic [31:0] BASE_WORD = 32'hE00F_F003,
    parameter logic [31:0] ID_WORD   = 32'h2477_0011
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [7:0]  req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [1:0]  rsp_ack,
    output logic [31:0] rsp_rdata,
    input  logic        abort_req,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ready
);
    reg_dec_t      dec;
    logic          is_data;
    logic          busy;
    logic          launch;
    mem_cmd_t      cmd;
    logic [AW-1:0] tar;
    logic [DW-1:0] reg_rdata;
    logic          rd_done, rd_abort;
    logic [DW-1:0] rd_data;

    logic          rv_q;
    ack_e          ack_q;
    logic [DW-1:0] rdata_q;

    mwp_decode u_dec (
        .ofs (req_addr),
        .dec (dec)
    );

    assign is_data = (dec.kind == RK_DATA);
    assign launch  = req_valid && is_data && !busy;
    assign cmd     = '{we:    req_write,
                       addr:  window_addr(tar, dec.banked, dec.bank),
                       wdata: req_wdata};

    mwp_regs #(
        .CFG_WORD  (CFG_WORD),
        .BASE_WORD (BASE_WORD),
        .ID_WORD   (ID_WORD)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (req_valid && req_write && !is_data),
        .kind  (dec.kind),
        .wdata (req_wdata),
        .busy  (busy),
        .tar   (tar),
        .rdata (reg_rdata)
    );

    mwp_xfer u_xfer (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .cmd       (cmd),
        .abort     (abort_req),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .rd_done   (rd_done),
        .rd_abort  (rd_abort),
        .rd_data   (rd_data)
    );

    // Immediate responses: register accesses, refused and posted window accesses
    always_ff @(posedge clk) begin
        if (rst) begin
            rv_q    <= 1'b0;
            ack_q   <= ACK_OK;
            rdata_q <= '0;
        end else begin
            rv_q    <= 1'b0;
            ack_q   <= ACK_OK;
            rdata_q <= '0;
            if (req_valid) begin
                if (!is_data) begin
                    rv_q    <= 1'b1;
                    rdata_q <= req_write ? '0 : reg_rdata;
                end else if (busy) begin
                    rv_q  <= 1'b1;
                    ack_q <= ACK_WAIT;
                end else if (req_write) begin
                    rv_q <= 1'b1;
                end
            end
        end
    end

    assign rsp_valid = rv_q || rd_done || rd_abort;
    assign rsp_ack   = rd_abort ? ACK_ABORT : (rd_done ? ACK_OK : ack_q);
    assign rsp_rdata = rd_done ? rd_data : (rd_abort ? '0 : rdata_q);

    // R8: a window access while busy is refused with WAIT
    p_wait_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid && is_data && busy |=> rsp_valid && rsp_ack == ACK_WAIT);
    // R11: non-window register accesses answer on the next cycle with OK
    p_reg_rsp_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid && !is_data |=> rsp_valid && rsp_ack == ACK_OK);
    // R6: banked window address combines TAR block and bank index
    p_bank_addr_r6: assert property (@(posedge clk) disable iff (rst)
        launch && dec.banked |=>
            mem_req && mem_addr[BLK_LSB-1:2] == $past(dec.bank)
            && mem_addr[AW-1:BLK_LSB] == $past(tar[AW-1:BLK_LSB]));
    // R4: a direct window write starts a memory write
    p_win_write_r4: assert property (@(posedge clk) disable iff (rst)
        launch && req_write |=> mem_req && mem_we && mem_wdata == $past(req_wdata));
endmodule

// File: tb/sim_mem_window_port.sv
module sim_mem_window_port;
    localparam logic [31:0] P_CFG  = 32'h0000_0001;
    localparam logic [31:0] P_BASE = 32'hE00F_F003;
    localparam logic [31:0] P_ID   = 32'h2477_0011;
    localparam logic [1:0]  A_OK = 2'b00, A_WAIT = 2'b01, A_ABT = 2'b10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_ack;
    logic [31:0] rsp_rdata;
    logic        abort_req = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    mem_window_port #(.CFG_WORD(P_CFG), .BASE_WORD(P_BASE), .ID_WORD(P_ID)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .abort_req(abort_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    typedef struct { logic [1:0] ack; logic [31:0] data; string tag; } rsp_exp_t;
    typedef struct { logic we; logic [31:0] addr; logic [31:0] wdata; string tag; } mem_exp_t;

    rsp_exp_t    rsp_q[$];
    mem_exp_t    mem_q[$];
    logic [31:0] store [logic [31:0]];
    int          checks = 0, fails = 0;
    int          lat = 0;
    bit          finished = 0;

    function automatic logic [31:0] memval(logic [31:0] a);
        if (store.exists(a)) return store[a];
        return a ^ 32'hC3C3_0000;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Response monitor: pop expected items as responses appear
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (rsp_q.size() == 0) begin
                chk(0, "R11", "unexpected response", {30'd0, rsp_ack}, 32'hFFFF_FFFF);
            end else begin
                rsp_exp_t e;
                e = rsp_q.pop_front();
                chk(rsp_ack == e.ack, e.tag, "ack", {30'd0, rsp_ack}, {30'd0, e.ack});
                chk(rsp_rdata == e.data, e.tag, "rdata", rsp_rdata, e.data);
            end
        end
    end

    // Memory model with programmable latency; checks each issued transaction
    bit          active = 0;
    int          cnt = 0;
    logic [64:0] cap;
    always @(negedge clk) begin
        if (rst) begin
            active = 0; mem_ready = 1'b0;
        end else if (mem_ready) begin
            mem_ready = 1'b0;
        end else if (mem_req) begin
            if (!active) begin
                active = 1; cnt = 0;
                cap = {mem_we, mem_addr, mem_wdata};
                if (mem_q.size() == 0) begin
                    chk(0, "R7", "unexpected transaction", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    mem_exp_t m;
                    m = mem_q.pop_front();
                    chk(mem_we == m.we, m.tag, "mem_we", {31'd0, mem_we}, {31'd0, m.we});
                    chk(mem_addr == m.addr, m.tag, "mem_addr", mem_addr, m.addr);
                    if (m.we) chk(mem_wdata == m.wdata, m.tag, "mem_wdata", mem_wdata, m.wdata);
                end
            end else begin
                chk(cap == {mem_we, mem_addr, mem_wdata}, "R7", "request held", mem_addr, cap[63:32]);
            end
            if (cnt >= lat) begin
                mem_ready = 1'b1;
                mem_rdata = memval(mem_addr);
                if (mem_we) store[mem_addr] = mem_wdata;
                active = 0;
            end else begin
                cnt++;
            end
        end else begin
            active = 0;
        end
    end

    task automatic issue(bit wr, logic [7:0] ofs, logic [31:0] wd,
                         logic [1:0] eack, logic [31:0] erd, string tag);
        rsp_q.push_back('{ack: eack, data: erd, tag: tag});
        req_valid = 1'b1; req_write = wr; req_addr = ofs; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic settle();
        while (rsp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic access(bit wr, logic [7:0] ofs, logic [31:0] wd,
                          logic [1:0] eack, logic [31:0] erd, string tag);
        issue(wr, ofs, wd, eack, erd, tag);
        settle();
    endtask

    task automatic expect_mem(logic we, logic [31:0] a, logic [31:0] d, string tag);
        mem_q.push_back('{we: we, addr: a, wdata: d, tag: tag});
    endtask

    task automatic wait_idle();
        while (mem_req) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] tr;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        chk(mem_req == 1'b0, "R1", "mem_req after reset", {31'd0, mem_req}, 32'd0);
        access(0, 8'h00, 0, A_OK, 32'h0, "R1");
        access(0, 8'h04, 0, A_OK, 32'h0, "R1");

        // R2 register storage
        access(1, 8'h04, 32'h2000_0107, A_OK, 0, "R2");
        access(0, 8'h04, 0, A_OK, 32'h2000_0107, "R2");
        access(1, 8'h00, 32'hFFFF_FFFF, A_OK, 0, "R2");
        access(0, 8'h00, 0, A_OK, 32'h0000_007F, "R2");
        access(1, 8'h00, 32'h0000_0015, A_OK, 0, "R2");
        access(0, 8'h00, 0, A_OK, 32'h0000_0015, "R2");

        // R3 constant words
        access(0, 8'hF4, 0, A_OK, P_CFG, "R3");
        access(0, 8'hF8, 0, A_OK, P_BASE, "R3");
        access(0, 8'hFC, 0, A_OK, P_ID, "R3");

        // R4 / R5 direct window, low address bits dropped
        lat = 0;
        expect_mem(1, 32'h2000_0104, 32'hA1B2_C3D4, "R4");
        access(1, 8'h0C, 32'hA1B2_C3D4, A_OK, 0, "R4");
        wait_idle();
        expect_mem(0, 32'h2000_0104, 0, "R5");
        access(0, 8'h0C, 0, A_OK, 32'hA1B2_C3D4, "R5");
        lat = 3;
        expect_mem(0, 32'h2000_0200, 0, "R5");
        access(1, 8'h04, 32'h2000_0200, A_OK, 0, "R5");
        access(0, 8'h0C, 0, A_OK, memval(32'h2000_0200), "R5");

        // R6 banked windows
        lat = 2;
        tr = 32'h3000_0028;
        access(1, 8'h04, tr, A_OK, 0, "R6");
        for (int n = 0; n < 4; n++) begin
            expect_mem(1, 32'h3000_0020 + 4 * n, 32'h0B0B_0000 + n, "R6");
            access(1, 8'(8'h10 + 4 * n), 32'h0B0B_0000 + n, A_OK, 0, "R6");
            wait_idle();
        end
        for (int n = 3; n >= 0; n--) begin
            expect_mem(0, 32'h3000_0020 + 4 * n, 0, "R6");
            access(0, 8'(8'h10 + 4 * n), 0, A_OK, 32'h0B0B_0000 + n, "R6");
        end
        expect_mem(0, 32'h3000_0028, 0, "R6");
        access(0, 8'h0C, 0, A_OK, 32'h0B0B_0002, "R6");

        // R8 busy flag and WAIT
        lat = 12;
        expect_mem(1, 32'h3000_0028, 32'h5555_AAAA, "R8");
        access(1, 8'h0C, 32'h5555_AAAA, A_OK, 0, "R8");
        access(0, 8'h00, 0, A_OK, 32'h0000_0095, "R8");
        access(1, 8'h0C, 32'h1234_5678, A_WAIT, 0, "R8");
        access(0, 8'h14, 0, A_WAIT, 0, "R8");
        wait_idle();
        access(0, 8'h00, 0, A_OK, 32'h0000_0015, "R8");
        lat = 1;
        expect_mem(0, 32'h3000_0028, 0, "R8");
        access(0, 8'h0C, 0, A_OK, 32'h5555_AAAA, "R8");

        // R9 read-only, undefined and misaligned offsets
        access(1, 8'hF4, 32'hDEAD_BEEF, A_OK, 0, "R9");
        access(1, 8'hFC, 32'hDEAD_BEEF, A_OK, 0, "R9");
        access(0, 8'hF4, 0, A_OK, P_CFG, "R9");
        access(0, 8'hFC, 0, A_OK, P_ID, "R9");
        access(1, 8'h08, 32'hFFFF_FFFF, A_OK, 0, "R9");
        access(0, 8'h08, 0, A_OK, 0, "R9");
        access(0, 8'h40, 0, A_OK, 0, "R9");
        access(1, 8'h05, 32'h0000_0000, A_OK, 0, "R9");
        access(1, 8'h0D, 32'h1111_1111, A_OK, 0, "R9");
        access(0, 8'h0E, 0, A_OK, 0, "R9");
        access(0, 8'h04, 0, A_OK, tr, "R9");
        chk(mem_q.size() == 0, "R9", "no transaction started", mem_q.size(), 0);

        // R10 abort of a read
        lat = 30;
        expect_mem(0, 32'h3000_0028, 0, "R10");
        issue(0, 8'h0C, 0, A_ABT, 0, "R10");
        repeat (3) @(negedge clk);
        abort_req = 1'b1;
        @(negedge clk);
        abort_req = 1'b0;
        chk(mem_req == 1'b0, "R10", "mem_req after abort", {31'd0, mem_req}, 0);
        settle();
        access(0, 8'h00, 0, A_OK, 32'h0000_0015, "R10");

        // R10 abort of a posted write: memory keeps old value
        expect_mem(1, 32'h3000_0028, 32'hFEED_0000, "R10");
        access(1, 8'h0C, 32'hFEED_0000, A_OK, 0, "R10");
        abort_req = 1'b1;
        @(negedge clk);
        abort_req = 1'b0;
        chk(mem_req == 1'b0, "R10", "mem_req after write abort", {31'd0, mem_req}, 0);
        access(0, 8'h00, 0, A_OK, 32'h0000_0015, "R10");
        lat = 0;
        expect_mem(0, 32'h3000_0028, 0, "R10");
        access(0, 8'h0C, 0, A_OK, 32'h5555_AAAA, "R10");

        // R10 abort while idle has no effect; R11 plain register timing
        abort_req = 1'b1;
        @(negedge clk);
        abort_req = 1'b0;
        chk(rsp_valid == 1'b0, "R10", "no response for idle abort", {31'd0, rsp_valid}, 0);
        access(0, 8'h04, 0, A_OK, tr, "R11");
        issue(0, 8'hF8, 0, A_OK, P_BASE, "R11");
        chk(rsp_valid == 1'b1, "R11", "response next cycle", {31'd0, rsp_valid}, 1);
        settle();
        chk(rsp_q.size() == 0 && mem_q.size() == 0, "R11", "all items consumed",
            rsp_q.size() + mem_q.size(), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule